// File: doc/BRIEF.md
# Cascadable Late-Parity Word Checker

This block checks parity over a 12-bit data word when the parity bit for that word arrives one clock after the word. The word is captured on every rising clock edge. On the next edge its parity is combined with the late parity bit and with a term from a shared parity/cascade pin, and the result is stored in an error register. The error register is seen through an open-drain style output that pulls low on error. Here that output is modelled as a pull-low enable.

A single checker sets the check sense through the parity/cascade pin: low means even parity, high means odd. Two checkers can be chained. The first one stops listening on its pin and drives the parity sum of its own delayed word onto it. The second one listens on its pin and folds that partial sum into its own check, so one late parity bit covers both words. The top bit of the incoming word also serves as an active-low load strobe for the error register. An output-off input masks the error output without touching the stored state.

Top module: `casc_parity_chk`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the error register and the captured word. After reset, err_pull is 0.
- R2: With listen=1 and pin_in=0 (even sense), the error register loads 1 exactly when the count of ones in the word sampled at edge k-1, plus par_late sampled at edge k, is odd. The new value is visible after edge k.
- R3: With listen=1 and pin_in=1 (odd sense), the error register loads 1 exactly when that same count is even.
- R4: With listen=0, pin_oe is 1 and pin_out equals the XOR of all bits of the word sampled at the previous edge. The block's own check then treats the pin term as 0. With listen=1, pin_oe is 0.
- R5: With listen=1, the value sampled on pin_in is XORed into the check at the same edge as par_late. This lets a partial sum from a first checker decide the result of a second checker.
- R6: The error register loads only at an edge where data_in bit 11 is 0. When bit 11 is 1, the register keeps its previous value.
- R7: While out_off is 1, err_pull is 0. The stored error is unaffected and reappears on err_pull once out_off returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, runs regardless of any data-path mode |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 12 | Data word; bit 11 is also the active-low error load strobe |
| par_late | input | 1 | Parity bit for the word presented one cycle earlier |
| listen | input | 1 | 1: pin is an input (sense or partial sum); 0: drive own sum |
| pin_in | input | 1 | Value seen on the parity/cascade pin |
| pin_out | output | 1 | Parity sum of the delayed word, driven when listen=0 |
| pin_oe | output | 1 | Drive enable for the parity/cascade pin |
| out_off | input | 1 | 1 forces the error output to high impedance |
| err_pull | output | 1 | 1 = pull the open-drain error line low (error present) |

## Verification
The assertions assume that par_late and pin_in are settled at the same edge, one edge after the word they belong to. They also assume that reset is held for at least one full edge. The checks that look back two edges stay disabled until two clean edges have followed reset. The bench changes every input on the falling edge and reads the outputs one nanosecond after the rising edge. Each parity bit therefore pairs with exactly the word driven one cycle earlier. The bench also keeps listen steady within a vector, so the pin's direction never changes mid-cycle.

// File: rtl/casc_parity_pkg.sv
package casc_parity_pkg;

    typedef enum logic {
        PIN_DRIVE  = 1'b0,
        PIN_LISTEN = 1'b1
    } pin_role_e;

    typedef struct packed {
        logic word_sum;
        logic late_bit;
        logic pin_term;
    } check_t;

    function automatic logic fold_xor(input logic [63:0] v, input int n);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i < n) acc = acc ^ v[i];
        end
        return acc;
    endfunction

    function automatic logic mismatch(input check_t c);
        return c.word_sum ^ c.late_bit ^ c.pin_term;
    endfunction

endpackage

// File: rtl/pcc_word_stage.sv
module pcc_word_stage #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    output logic              dly_sum
);
    import casc_parity_pkg::*;

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_in;
    end

    assign dly_sum = fold_xor(64'(word_q), WORD_W);

endmodule

// File: rtl/pcc_err_stage.sv
module pcc_err_stage (
    input  logic                    clk,
    input  logic                    rst,
    input  casc_parity_pkg::check_t chk,
    input  logic                    load_n,
    output logic                    err_q
);
    import casc_parity_pkg::*;

    logic err_d;

    always_comb begin
        err_d = err_q;
        if (!load_n) err_d = mismatch(chk);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_d;
    end

endmodule

// File: rtl/casc_parity_chk.sv
module casc_parity_chk #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] data_in,
    input  logic              par_late,
    input  logic              listen,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    input  logic              out_off,
    output logic              err_pull
);
    import casc_parity_pkg::*;

    localparam int LOAD_BIT = WORD_W - 1;

    pin_role_e role;
    logic      dly_sum;
    check_t    chk;
    logic      err_q;

    assign role = listen ? PIN_LISTEN : PIN_DRIVE;

    pcc_word_stage #(.WORD_W(WORD_W)) u_word (
        .clk     (clk),
        .rst     (rst),
        .word_in (data_in),
        .dly_sum (dly_sum)
    );

    always_comb begin
        chk.word_sum = dly_sum;
        chk.late_bit = par_late;
        chk.pin_term = (role == PIN_LISTEN) ? pin_in : 1'b0;
    end

    pcc_err_stage u_err (
        .clk    (clk),
        .rst    (rst),
        .chk    (chk),
        .load_n (data_in[LOAD_BIT]),
        .err_q  (err_q)
    );

    assign pin_oe   = (role == PIN_DRIVE);
    assign pin_out  = (role == PIN_DRIVE) ? dly_sum : 1'b0;
    assign err_pull = err_q & ~out_off;

endmodule

// File: rtl/casc_parity_chk_sva.sv
module casc_parity_chk_sva #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] data_in,
    input logic              par_late,
    input logic              listen,
    input logic              pin_in,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              out_off,
    input logic              err_pull,
    input logic              err_q
);
    localparam int LOAD_BIT = WORD_W - 1;

    logic [1:0] clean;

    always_ff @(posedge clk) begin
        if (rst)                clean <= 2'd0;
        else if (clean != 2'd2) clean <= clean + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !err_q);

    p_check_result_r2: assert property (@(posedge clk) disable iff (rst)
        (clean == 2'd2 && !data_in[LOAD_BIT]) |=>
        (err_q == ((^$past(data_in, 2)) ^ $past(par_late) ^ ($past(listen) & $past(pin_in)))));

    p_drive_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (clean != 2'd0 && !listen) |-> (pin_oe && pin_out == (^$past(data_in))));

    p_listen_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
        listen |-> !pin_oe);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        data_in[LOAD_BIT] |=> $stable(err_q));

    p_masked_r7: assert property (@(posedge clk) disable iff (rst)
        out_off |-> !err_pull);

endmodule

bind casc_parity_chk casc_parity_chk_sva #(.WORD_W(WORD_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .par_late (par_late),
    .listen   (listen),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .out_off  (out_off),
    .err_pull (err_pull),
    .err_q    (err_q)
);

// File: tb/casc_parity_chk_test.sv
`timescale 1ns/1ps
module casc_parity_chk_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] data_in;
    logic        par_late, listen, pin_in, out_off;
    logic        pin_out, pin_oe, err_pull;

    int compared   = 0;
    int mismatched = 0;
    logic [11:0] prev_word = '0;
    logic        exp_err   = 1'b0;
    bit          done      = 1'b0;

    always #5 clk = ~clk;

    casc_parity_chk uut (
        .clk(clk), .rst(rst), .data_in(data_in), .par_late(par_late),
        .listen(listen), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .out_off(out_off), .err_pull(err_pull)
    );

    // vector fields: {listen, pin_in, par_late, word[11:0]}
    localparam int NV = 16;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 12'h000},   // R2 even sense
        {1'b1, 1'b0, 1'b0, 12'h001},
        {1'b1, 1'b0, 1'b1, 12'h003},   // R2 parity pairs with previous word
        {1'b1, 1'b0, 1'b0, 12'h7FF},
        {1'b1, 1'b0, 1'b1, 12'h155},
        {1'b1, 1'b1, 1'b0, 12'h2AA},   // R3 odd sense
        {1'b1, 1'b1, 1'b1, 12'h0F0},
        {1'b1, 1'b1, 1'b0, 12'h00F},
        {1'b1, 1'b1, 1'b1, 12'h123},
        {1'b0, 1'b1, 1'b0, 12'h456},   // R4 drive own sum
        {1'b0, 1'b0, 1'b1, 12'h3C1},
        {1'b0, 1'b1, 1'b0, 12'h081},
        {1'b1, 1'b1, 1'b0, 12'h011},   // R5 partial sum folded in
        {1'b1, 1'b0, 1'b0, 12'h7AB},
        {1'b1, 1'b1, 1'b1, 12'h6CC},
        {1'b1, 1'b0, 1'b1, 12'h001}
    };

    function automatic logic ones_odd(input logic [11:0] w);
        int n = 0;
        for (int i = 0; i < 12; i++) if (w[i]) n++;
        return (n % 2) == 1;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [11:0] w, input logic p, input logic s,
                        input logic l, input logic off, input string req);
        @(negedge clk);
        data_in = w; par_late = p; pin_in = s; listen = l; out_off = off;
        @(posedge clk);
        if (!w[11]) exp_err = ones_odd(prev_word) ^ p ^ (l & s);
        prev_word = w;
        #1;
        check(req, err_pull, exp_err & ~off);
        check("R4 pin_oe", pin_oe, ~l);
        if (!l) check("R4 pin_out", pin_out, ones_odd(w));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; data_in = '0; par_late = 0; listen = 1; pin_in = 0; out_off = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset err", err_pull, 1'b0);
        check("R4 listen pin_oe", pin_oe, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            step(VEC[i][11:0], VEC[i][12], VEC[i][13], VEC[i][14], 1'b0, "R2/R3/R5 vector");

        // R2: force a known error, then confirm it holds while bit 11 is 1 (R6)
        step(12'h001, 1'b0, 1'b0, 1'b1, 1'b0, "R2 setup");
        step(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, "R2 odd ones flags error");
        check("R2 error visible", err_pull, 1'b1);
        step(12'h800, 1'b0, 1'b0, 1'b1, 1'b0, "R6 hold set");
        step(12'h800, 1'b1, 1'b0, 1'b1, 1'b0, "R6 hold with good parity");
        check("R6 error retained", err_pull, 1'b1);
        // R7: mask and unmask, error stays stored
        step(12'h800, 1'b0, 1'b0, 1'b1, 1'b1, "R7 masked");
        check("R7 masked output", err_pull, 1'b0);
        step(12'h800, 1'b0, 1'b0, 1'b1, 1'b0, "R7 unmasked");
        check("R7 error reappears", err_pull, 1'b1);
        // R5: pin term clears the mismatch of an odd word
        step(12'h001, 1'b0, 1'b0, 1'b1, 1'b0, "R5 setup");
        step(12'h000, 1'b0, 1'b1, 1'b1, 1'b0, "R5 partial sum cancels");
        check("R5 no error", err_pull, 1'b0);
        // R1: reset clears a stored error
        step(12'h001, 1'b0, 1'b0, 1'b1, 1'b0, "R1 setup");
        step(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, "R1 error set");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset clears error", err_pull, 1'b0);
        exp_err = 1'b0; prev_word = '0;
        @(negedge clk); rst = 1'b0;
        step(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, "R1 cleared word");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule